// File: doc/BRIEF.md
# Linear Image Sensor Line Sequencer

This block drives a two-section linear photodiode array of 1536 pixels. It produces a free-running sensor clock and the start pulses for both sections. It also produces a one-cycle strobe with a pixel index, so that an external converter can sample each pixel as it appears on the analog outputs. The sections can be chained, with the first section's shift-out feeding the second, so one line is 1536 pixels long. They can also be started together, so each section delivers 768 pixels at the same time.

A line starts with a start pulse that is high across exactly one rising edge of the sensor clock. That edge is the capture edge. The readout then needs one rising edge per pixel, plus one more edge to end the last shift-out pulse. The next start pulse is held back for a charge-transfer gap, which is clamped to at least one clock, and then for a programmable number of extra integration clocks. The integrators restart 18 clocks after each capture edge. The integration window is therefore the capture-to-capture period minus 18 clocks, and the gap and extra settings lengthen it. A run input starts free-running operation. Dropping run stops the sequence only at a line boundary. The mode, gap and extra settings are sampled when each start pulse is launched.

Top module: `linesense_host`

## Requirements
- R1: The sensor clock output is low in reset and toggles every HALF_DIV system clocks, so it has one rising edge every 2*HALF_DIV system clocks.
- R2: Each start pulse changes level only while the sensor clock is low (on its falling phase). It is high across exactly one rising edge, the capture edge.
- R3: In chained mode (par_mode = 0) only si1 pulses and si2 stays low. A line then delivers 1536 pixel strobes with indices 0 to 1535.
- R4: In side-by-side mode (par_mode = 1) si1 and si2 pulse together. A line then delivers 768 strobes with indices 0 to 767, one strobe covering both sections.
- R5: pix_valid is high for one system cycle, the cycle in which the sensor clock goes high, on each of rising edges 1 to N after the capture edge. pix_idx gives the index of edge k as k-1 and holds its value otherwise.
- R6: frame_start is high for one system cycle, in the cycle where the sensor clock goes high at the capture edge.
- R7: frame_end is high for one system cycle on rising edge N+1 after the capture edge (edge 1537 in chained mode, edge 769 in side-by-side mode). This is the edge that ends the final shift-out pulse. It never coincides with a pixel strobe.
- R8: While run stays high, consecutive capture edges are exactly N + 2 + max(gap,1) + extra sensor rising edges apart. The integration window is that period minus 18 clocks.
- R9: A gap setting of 0 acts as 1, so at least one rising edge always passes between frame_end and the next capture edge.
- R10: Lowering run mid-line lets the current line finish, including frame_end, and then issues no start pulse. Raising run again from idle launches a start pulse at the next falling phase.
- R11: par_mode, gap and extra are sampled when a start pulse is launched. Changing them mid-line does not alter the line in progress or the gap that follows it.
- R12: During reset si1, si2, pix_valid, frame_start, frame_end and the sensor clock are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Free-running enable, honoured at line boundaries |
| par_mode | input | 1 | 0 = chained sections, 1 = sections started together |
| gap | input | GAP_W | Charge-transfer gap in sensor clocks, 0 treated as 1 |
| extra | input | EXTRA_W | Extra integration clocks added after the gap |
| sclk | output | 1 | Sensor clock |
| si1 | output | 1 | Start pulse for section 1 |
| si2 | output | 1 | Start pulse for section 2 (side-by-side mode only) |
| pix_valid | output | 1 | One-cycle pixel sample strobe |
| pix_idx | output | IDX_W | Index of the strobed pixel |
| frame_start | output | 1 | Capture-edge pulse |
| frame_end | output | 1 | Terminating-edge pulse |

## Verification
Several properties are checked on every cycle. Start pulses may change only in the low phase of the sensor clock, and the capture edge must see si1 high. Pixel strobes must coincide with a rising sensor clock, indices must rise by one with no gaps and stay within the line length of the latched mode, and the three event strobes must never overlap. The last index before frame_end must be the final pixel, and at least one rising edge must separate frame_end from the next capture. Some behaviour can only be shown by the bench scenarios: the exact capture-to-capture period for each gap and extra setting, the clamping of a zero gap, the completion of a line after run is dropped followed by silence, and the immunity of a running line to configuration changes.

// File: rtl/lsh_pkg.sv
package lsh_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ARM,
    PH_READ,
    PH_WAIT
  } phase_t;

  // Pixels delivered by one line for the selected section arrangement.
  function automatic int unsigned line_pixels(input logic par, input int unsigned total);
    return par ? (total / 2) : total;
  endfunction

  // Rising edges between the terminating edge and the next launch.
  function automatic int unsigned wait_clocks(input int unsigned gap_v, input int unsigned extra_v);
    return ((gap_v == 0) ? 1 : gap_v) + extra_v;
  endfunction

endpackage

// File: rtl/lsh_clkgen.sv
module lsh_clkgen #(
  parameter int HALF_DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic sclk,
  output logic rise_evt,
  output logic fall_evt
);

  logic wrap;

  generate
    if (HALF_DIV <= 1) begin : g_nodiv
      assign wrap = 1'b1;
    end else begin : g_div
      localparam int HC_W = $clog2(HALF_DIV);
      localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF_DIV - 1);
      logic [HC_W-1:0] hc;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             hc <= '0;
        else if (hc == HC_LAST) hc <= '0;
        else                    hc <= hc + HC_W'(1);
      end
      assign wrap = (hc == HC_LAST);
    end
  endgenerate

  // Events mark the system cycle before the sensor clock changes level.
  assign rise_evt = wrap & ~sclk;
  assign fall_evt = wrap & sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sclk <= 1'b0;
    else if (wrap) sclk <= ~sclk;
  end

endmodule

// File: rtl/lsh_seq.sv
module lsh_seq
  import lsh_pkg::*;
#(
  parameter int NPIX_TOTAL = 1536,
  parameter int GAP_W      = 8,
  parameter int EXTRA_W    = 16,
  localparam int CNT_W     = $clog2(NPIX_TOTAL + 1),
  localparam int WAIT_W    = ((GAP_W > EXTRA_W) ? GAP_W : EXTRA_W) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rise_evt,
  input  logic               fall_evt,
  input  logic               run,
  input  logic               par_mode,
  input  logic [GAP_W-1:0]   gap,
  input  logic [EXTRA_W-1:0] extra,
  output logic               si_lvl,
  output logic               line_par,
  output logic [CNT_W-1:0]   cnt,
  output logic               capture_evt,
  output logic               pix_evt,
  output logic               term_evt
);

  phase_t              phase;
  logic [WAIT_W-1:0]   wcnt;
  logic [WAIT_W-1:0]   w_lat;
  logic [CNT_W-1:0]    line_n;
  logic                wait_reached;
  logic                launch_evt;
  logic                park_evt;

  assign line_n       = CNT_W'(line_pixels(line_par, NPIX_TOTAL));
  assign wait_reached = (phase == PH_WAIT) && (wcnt == w_lat);
  assign launch_evt   = fall_evt && run && ((phase == PH_IDLE) || wait_reached);
  assign park_evt     = fall_evt && !run && wait_reached;
  assign capture_evt  = rise_evt && (phase == PH_ARM);
  assign pix_evt      = rise_evt && (phase == PH_READ) && (cnt < line_n);
  assign term_evt     = rise_evt && (phase == PH_READ) && (cnt == line_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      wcnt     <= '0;
      w_lat    <= WAIT_W'(1);
      line_par <= 1'b0;
      si_lvl   <= 1'b0;
    end else begin
      if (fall_evt) si_lvl <= launch_evt;
      if (launch_evt) begin
        phase    <= PH_ARM;
        line_par <= par_mode;
        w_lat    <= WAIT_W'(wait_clocks(32'(gap), 32'(extra)));
      end else if (park_evt) begin
        phase <= PH_IDLE;
      end else if (capture_evt) begin
        phase <= PH_READ;
        cnt   <= '0;
      end else if (pix_evt) begin
        cnt <= cnt + CNT_W'(1);
      end else if (term_evt) begin
        phase <= PH_WAIT;
        wcnt  <= '0;
      end else if (rise_evt && (phase == PH_WAIT) && !wait_reached) begin
        wcnt <= wcnt + WAIT_W'(1);
      end
    end
  end

endmodule

// File: rtl/lsh_strobe.sv
module lsh_strobe #(
  parameter int CNT_W = 11,
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_evt,
  input  logic             capture_evt,
  input  logic             term_evt,
  input  logic [CNT_W-1:0] cnt,
  output logic             pix_valid,
  output logic [IDX_W-1:0] pix_idx,
  output logic             frame_start,
  output logic             frame_end
);

  // Registered so every strobe lines up with the sensor clock going high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_valid   <= 1'b0;
      pix_idx     <= '0;
      frame_start <= 1'b0;
      frame_end   <= 1'b0;
    end else begin
      pix_valid   <= pix_evt;
      frame_start <= capture_evt;
      frame_end   <= term_evt;
      if (pix_evt) pix_idx <= IDX_W'(cnt);
    end
  end

endmodule

// File: rtl/linesense_host.sv
module linesense_host #(
  parameter int NPIX_TOTAL = 1536,
  parameter int HALF_DIV   = 1,
  parameter int GAP_W      = 8,
  parameter int EXTRA_W    = 16,
  localparam int IDX_W     = $clog2(NPIX_TOTAL),
  localparam int CNT_W     = $clog2(NPIX_TOTAL + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               par_mode,
  input  logic [GAP_W-1:0]   gap,
  input  logic [EXTRA_W-1:0] extra,
  output logic               sclk,
  output logic               si1,
  output logic               si2,
  output logic               pix_valid,
  output logic [IDX_W-1:0]   pix_idx,
  output logic               frame_start,
  output logic               frame_end
);

  logic             rise_evt;
  logic             fall_evt;
  logic             si_lvl;
  logic             line_par;
  logic [CNT_W-1:0] cnt;
  logic             capture_evt;
  logic             pix_evt;
  logic             term_evt;

  lsh_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk     (sclk),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  lsh_seq #(
    .NPIX_TOTAL (NPIX_TOTAL),
    .GAP_W      (GAP_W),
    .EXTRA_W    (EXTRA_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .rise_evt    (rise_evt),
    .fall_evt    (fall_evt),
    .run         (run),
    .par_mode    (par_mode),
    .gap         (gap),
    .extra       (extra),
    .si_lvl      (si_lvl),
    .line_par    (line_par),
    .cnt         (cnt),
    .capture_evt (capture_evt),
    .pix_evt     (pix_evt),
    .term_evt    (term_evt)
  );

  lsh_strobe #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_stb (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_evt     (pix_evt),
    .capture_evt (capture_evt),
    .term_evt    (term_evt),
    .cnt         (cnt),
    .pix_valid   (pix_valid),
    .pix_idx     (pix_idx),
    .frame_start (frame_start),
    .frame_end   (frame_end)
  );

  // Section 2 is started directly only when the sections run side by side.
  assign si1 = si_lvl;
  assign si2 = si_lvl & line_par;

endmodule

// File: rtl/linesense_host_chk.sv
module linesense_host_chk #(
  parameter int NPIX_TOTAL = 1536,
  parameter int IDX_W      = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sclk,
  input logic             si1,
  input logic             pix_valid,
  input logic [IDX_W-1:0] pix_idx,
  input logic             frame_start,
  input logic             frame_end,
  input logic             line_par
);

  logic [IDX_W-1:0] last_idx;
  logic             sclk_q;
  logic             seen_end;
  logic [1:0]       gap_rises;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_idx  <= '0;
      sclk_q    <= 1'b0;
      seen_end  <= 1'b0;
      gap_rises <= '0;
    end else begin
      sclk_q <= sclk;
      if (pix_valid) last_idx <= pix_idx;
      if (frame_end) begin
        seen_end  <= 1'b1;
        gap_rises <= '0;
      end else if (sclk && !sclk_q && gap_rises != 2'd3) begin
        gap_rises <= gap_rises + 2'd1;
      end
    end
  end

  // R2
  si_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(si1) |-> !sclk);

  // R2
  si_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> si1);

  // R5
  strobe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> $rose(sclk));

  // R5
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_idx != '0) |-> (pix_idx == last_idx + IDX_W'(1)));

  // R3 R4
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (int'(pix_idx) < (line_par ? NPIX_TOTAL / 2 : NPIX_TOTAL)));

  // R7
  event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_start, frame_end, pix_valid}));

  // R7
  last_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> (int'(last_idx) == (line_par ? NPIX_TOTAL / 2 : NPIX_TOTAL) - 1));

  // R9
  min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (!seen_end || gap_rises >= 2'd1));

endmodule

bind linesense_host linesense_host_chk #(
  .NPIX_TOTAL (NPIX_TOTAL),
  .IDX_W      (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sclk        (sclk),
  .si1         (si1),
  .pix_valid   (pix_valid),
  .pix_idx     (pix_idx),
  .frame_start (frame_start),
  .frame_end   (frame_end),
  .line_par    (line_par)
);

// File: tb/sim_linesense_host.sv
module sim_linesense_host;

  localparam int N  = 1536;
  localparam int HD = 1;
  localparam int GW = 8;
  localparam int EW = 16;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run = 1'b0;
  logic          par_mode = 1'b0;
  logic [GW-1:0] gap = '0;
  logic [EW-1:0] extra = '0;
  logic          sclk, si1, si2, pix_valid, frame_start, frame_end;
  logic [IW-1:0] pix_idx;

  always #4 clk = ~clk;

  linesense_host #(.NPIX_TOTAL(N), .HALF_DIV(HD), .GAP_W(GW), .EXTRA_W(EW)) u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .par_mode(par_mode), .gap(gap), .extra(extra),
    .sclk(sclk), .si1(si1), .si2(si2), .pix_valid(pix_valid), .pix_idx(pix_idx),
    .frame_start(frame_start), .frame_end(frame_end)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: absolute rise numbers, updated at every system edge.
  int c = 0, rises = 0, want = 0, cap = -1, next_cap = -1, ln = N, lw = 1;
  bit idle = 1;
  bit e_sclk = 0, e_si1 = 0, e_si2 = 0, e_pv = 0, e_fs = 0, e_fe = 0;
  int e_idx = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      c = 0; rises = 0; want = 0; cap = -1; next_cap = -1; idle = 1;
      e_sclk = 0; e_si1 = 0; e_si2 = 0; e_pv = 0; e_fs = 0; e_fe = 0;
    end else begin
      c++;
      e_pv = 0; e_fs = 0; e_fe = 0;
      if (c % HD == 0) begin
        if (((c / HD) % 2) == 1) begin
          rises++;
          e_sclk = 1;
          if (rises == next_cap) begin
            e_fs = 1; cap = rises; next_cap = -1;
          end else if (cap >= 0 && rises > cap && rises <= cap + ln) begin
            e_pv = 1; e_idx = rises - cap - 1;
          end else if (cap >= 0 && rises == cap + ln + 1) begin
            e_fe = 1; idle = 1; want = rises + lw;
          end
        end else begin
          e_sclk = 0; e_si1 = 0; e_si2 = 0;
          if (idle && rises >= want && run) begin
            e_si1 = 1; e_si2 = par_mode; idle = 0; next_cap = rises + 1;
            ln = par_mode ? N / 2 : N;
            lw = ((gap == 0) ? 1 : int'(gap)) + int'(extra);
          end
        end
      end
    end
  end

  // Independent line monitors: pixel count per line and capture period.
  int  pc = 0, mode_n = N, rc = 0, rc_cap = 0, per_exp = 0;
  bit  have_prev = 0, skip_period = 0, sclk_prev = 0, zero_gap = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(sclk == e_sclk, "R1 sclk", sclk, e_sclk);
      chk(si1 == e_si1, "R2 si1", si1, e_si1);
      chk(si2 == e_si2, "R3 R4 si2", si2, e_si2);
      chk(pix_valid == e_pv, "R5 pix_valid", pix_valid, e_pv);
      if (e_pv) chk(int'(pix_idx) == e_idx, "R5 pix_idx", pix_idx, e_idx);
      chk(frame_start == e_fs, "R6 frame_start", frame_start, e_fs);
      chk(frame_end == e_fe, "R7 frame_end", frame_end, e_fe);

      if (sclk && !sclk_prev) rc++;
      sclk_prev = sclk;
      if (pix_valid) pc++;
      if (frame_end) chk(pc == mode_n, "R3 R4 R11 pixels per line", pc, mode_n);
      if (frame_start) begin
        if (have_prev && !skip_period) begin
          if (zero_gap) chk(rc - rc_cap == per_exp, "R8 R9 period with gap 0", rc - rc_cap, per_exp);
          else          chk(rc - rc_cap == per_exp, "R8 period", rc - rc_cap, per_exp);
        end
        skip_period = 0;
        have_prev = 1;
        rc_cap = rc;
        pc = 0;
        mode_n = par_mode ? N / 2 : N;
        zero_gap = (gap == 0);
        per_exp = mode_n + 2 + ((gap == 0) ? 1 : int'(gap)) + int'(extra);
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R12: outputs quiet in reset
    chk(sclk == 0 && si1 == 0 && si2 == 0, "R12 reset clock/start", {sclk, si1, si2}, 0);
    chk(pix_valid == 0 && frame_start == 0 && frame_end == 0, "R12 reset strobes",
        {pix_valid, frame_start, frame_end}, 0);
    run = 1; par_mode = 0; gap = 0; extra = 0;
    @(negedge clk);
    rst_n = 1;

    // Chained mode, zero gap clamped (R3, R9)
    repeat (3) @(posedge frame_end);

    // Side-by-side mode with gap and extra (R4, R8); changed mid-line (R11)
    @(posedge frame_start);
    repeat (3) @(negedge clk);
    par_mode = 1; gap = 5; extra = 40;
    repeat (3) @(posedge frame_end);

    // Mid-line change back to chained must not touch the running line (R11)
    @(posedge frame_start);
    repeat (200) @(negedge clk);
    par_mode = 0; gap = 3; extra = 7;
    repeat (2) @(posedge frame_end);

    // Stop mid-line (R10)
    @(posedge frame_start);
    repeat (100) @(negedge clk);
    run = 0;
    skip_period = 1;
    @(posedge frame_end);
    @(negedge clk);
    chk(pc == N, "R10 line completes after stop", pc, N);
    begin
      int highs = 0;
      for (int i = 0; i < 3000; i++) begin
        @(negedge clk);
        if (si1 || frame_start) highs++;
      end
      chk(highs == 0, "R10 no start while stopped", highs, 0);
    end
    run = 1;
    begin
      int wait_cyc = 0;
      while (!frame_start && wait_cyc < 20) begin
        @(negedge clk);
        wait_cyc++;
      end
      chk(frame_start == 1, "R10 restart from idle", frame_start, 1);
    end
    repeat (2) @(posedge frame_end);
    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule